// File: doc/BRIEF.md
# Serial Command Sequencer with Ready Handshake

This block is the host side of a serial link to a peripheral that takes 16-bit command words and may answer. A command arrives on a valid/ready port as a 4-bit code and a 10-bit value. The block packs it into a frame and shifts it out MSB first while a frame-select line is held low. Data changes on the rising serial-clock edge and is held across the falling edge, where the peripheral latches it.

After every frame the block watches the peripheral's busy line, which is passed through a two-flop synchronizer. It does not release the link until that line has been seen low and then high again. A time limit bounds the wait, and the limit depends on the class of the command. If the limit runs out, a sticky error flag is set and the block returns to idle. The select line is also held high for a minimum number of cycles between frames.

A readback code is followed at once by a second, all-zero frame. That frame is clocked at a slower rate so that slow peripheral output is covered. The last 10 bits sampled during it are returned with a one-cycle valid pulse. At start-up the block drives a reset pulse to the peripheral and then waits a power-up period before it accepts any command.

Top module: `ser_cmd_seq`

## Requirements
- R1: After `rst` is released, `dev_rst_n` stays low for exactly RST_CYC cycles. Then `cmd_ready` stays low for exactly PWRUP_CYC further cycles. During reset, `dev_sel_n`=1, `dev_sclk`=1, `cmd_ready`=0, `rsp_valid`=0 and `err_timeout`=0.
- R2: A frame carries 16 bits, MSB first: bits 15:14 are zero, bits 13:10 are the command code and bits 9:0 are the data value. `dev_dout` changes only while `dev_sclk` is high, or at its rising edge, and holds through each falling edge. `dev_sclk` is high whenever `dev_sel_n` is high.
- R3: In a command frame each `dev_sclk` phase lasts HALF_CYC cycles. `dev_sel_n` is low for exactly 32*HALF_CYC cycles.
- R4: Between two frames `dev_sel_n` stays high for at least GAP_CYC cycles.
- R5: A new frame starts only after the synchronized `dev_rdy` has been seen low and then high following the previous frame. `dev_rdy` is therefore high for at least 2 cycles when `dev_sel_n` falls, unless a timeout has occurred.
- R6: If the busy wait exceeds its limit, `err_timeout` is set and the block returns to idle. Any pending readback frame and its result are dropped.
- R7: `cmd_ready` is high only in idle, never while a frame is in progress. One command is taken per accepted handshake.
- R8: Codes 0x2 and 0x5 are readback codes. Each is followed by a frame with code 0x0 and data 0x000, whose phases last RB_HALF_CYC cycles. `dev_din` is sampled at the end of each high phase. The low 10 sampled bits appear on `rsp_data` with a one-cycle `rsp_valid` pulse once that frame's busy wait completes. Other codes produce no response.
- R9: The busy limit is TO_LONG for codes 0x3 and 0x5, TO_READ for code 0x2 and TO_SHORT for all other codes and for the response frame.
- R10: `err_timeout` stays set until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_code | input | 4 | Command code |
| cmd_data | input | 10 | Command data value |
| rsp_valid | output | 1 | One-cycle readback result strobe |
| rsp_data | output | 10 | Readback result |
| err_timeout | output | 1 | Sticky busy-timeout flag |
| dev_rst_n | output | 1 | Active-low reset to peripheral |
| dev_sel_n | output | 1 | Active-low frame select |
| dev_sclk | output | 1 | Serial clock, idle high |
| dev_dout | output | 1 | Serial data to peripheral |
| dev_din | input | 1 | Serial data from peripheral |
| dev_rdy | input | 1 | Peripheral ready (low while busy) |

## Verification
`dev_sel_n` falls one cycle after the accepting edge. It rises 32*HALF_CYC cycles later, or 32*RB_HALF_CYC cycles later for a response frame. `rsp_valid` pulses after the synchronized ready line returns high, which is two to three cycles after the pin itself. The bench samples every signal on the falling clock edge and measures frame lengths, gaps and reset intervals as differences of cycle counts at those samples. Results that depend on the ready handshake are read only after `cmd_ready` has come back high, so no check depends on the exact busy latency. The reset-to-ready intervals are counted sample by sample from the cycle in which `rst` drops.

// File: rtl/scs_pkg.sv
package scs_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CODE_W     = 4;
    localparam int DATA_W     = 10;
    localparam int PAD_W      = FRAME_BITS - CODE_W - DATA_W;

    localparam logic [CODE_W-1:0] OP_NOP      = 4'h0;
    localparam logic [CODE_W-1:0] OP_REG_RD   = 4'h2;
    localparam logic [CODE_W-1:0] OP_MEM_PROG = 4'h3;
    localparam logic [CODE_W-1:0] OP_MEM_RD   = 4'h5;

    typedef enum logic [1:0] {
        CLS_SHORT,
        CLS_READ,
        CLS_LONG
    } wait_cls_e;

    typedef enum logic [2:0] {
        ST_RST,
        ST_PWR,
        ST_IDLE,
        ST_FRAME,
        ST_BUSY,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic wait_cls_e cls_of(input logic [CODE_W-1:0] c);
        if (c == OP_MEM_PROG || c == OP_MEM_RD) return CLS_LONG;
        if (c == OP_REG_RD) return CLS_READ;
        return CLS_SHORT;
    endfunction

    function automatic logic is_readback(input logic [CODE_W-1:0] c);
        return (c == OP_REG_RD) || (c == OP_MEM_RD);
    endfunction

    function automatic logic [FRAME_BITS-1:0] pack_frame(input cmd_t c);
        return {{PAD_W{1'b0}}, c.code, c.data};
    endfunction

endpackage

// File: rtl/scs_sync2.sv
module scs_sync2 #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scs_frame_shift.sv
module scs_frame_shift #(
    parameter int NBITS = 16,
    parameter int RX_W  = 10,
    parameter int HW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NBITS-1:0] word,
    input  logic [HW-1:0]    half,
    input  logic             din,
    output logic             sel_n,
    output logic             sclk,
    output logic             dout,
    output logic             done,
    output logic [RX_W-1:0]  rx
);
    localparam int BW = $clog2(NBITS);

    logic             active;
    logic             phase_lo;
    logic [HW-1:0]    cnt;
    logic [HW-1:0]    half_q;
    logic [BW-1:0]    bitc;
    logic [NBITS-1:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            phase_lo <= 1'b0;
            cnt      <= '0;
            half_q   <= '0;
            bitc     <= '0;
            tx       <= '0;
            rx       <= '0;
            sel_n    <= 1'b1;
            sclk     <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    sel_n    <= 1'b0;
                    sclk     <= 1'b1;
                    phase_lo <= 1'b0;
                    cnt      <= '0;
                    half_q   <= half;
                    bitc     <= BW'(NBITS - 1);
                    tx       <= word;
                    rx       <= '0;
                end
            end else if (cnt == half_q - HW'(1)) begin
                cnt <= '0;
                if (!phase_lo) begin
                    // end of high phase: sample input, then drop the clock
                    sclk     <= 1'b0;
                    phase_lo <= 1'b1;
                    rx       <= {rx[RX_W-2:0], din};
                end else if (bitc == '0) begin
                    active   <= 1'b0;
                    sel_n    <= 1'b1;
                    sclk     <= 1'b1;
                    phase_lo <= 1'b0;
                    done     <= 1'b1;
                    tx       <= '0;
                end else begin
                    bitc     <= bitc - BW'(1);
                    sclk     <= 1'b1;
                    phase_lo <= 1'b0;
                    tx       <= {tx[NBITS-2:0], 1'b0};
                end
            end else begin
                cnt <= cnt + HW'(1);
            end
        end
    end

    assign dout = tx[NBITS-1];
endmodule

// File: rtl/scs_busy_mon.sv
module scs_busy_mon #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          rdy_ok,
    input  logic [TW-1:0] limit,
    output logic          ok,
    output logic          tout
);
    logic          run;
    logic          seen_low;
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            seen_low <= 1'b0;
            cnt      <= '0;
            ok       <= 1'b0;
            tout     <= 1'b0;
        end else begin
            ok   <= 1'b0;
            tout <= 1'b0;
            if (arm) begin
                run      <= 1'b1;
                seen_low <= 1'b0;
                cnt      <= '0;
            end else if (run) begin
                if (seen_low && rdy_ok) begin
                    ok  <= 1'b1;
                    run <= 1'b0;
                end else if (cnt == limit - TW'(1)) begin
                    tout <= 1'b1;
                    run  <= 1'b0;
                end else begin
                    cnt <= cnt + TW'(1);
                    if (!rdy_ok) seen_low <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ser_cmd_seq.sv
module ser_cmd_seq
    import scs_pkg::*;
#(
    parameter int HALF_CYC    = 2,
    parameter int RB_HALF_CYC = 4,
    parameter int GAP_CYC     = 8,
    parameter int RST_CYC     = 4,
    parameter int PWRUP_CYC   = 20,
    parameter int TO_SHORT    = 20,
    parameter int TO_READ     = 60,
    parameter int TO_LONG     = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              err_timeout,
    output logic              dev_rst_n,
    output logic              dev_sel_n,
    output logic              dev_sclk,
    output logic              dev_dout,
    input  logic              dev_din,
    input  logic              dev_rdy
);
    localparam int HW    = $clog2(max2(HALF_CYC, RB_HALF_CYC) + 1);
    localparam int MAX_T = max2(max2(TO_LONG, TO_READ), max2(max2(TO_SHORT, PWRUP_CYC), RST_CYC));
    localparam int TW    = $clog2(MAX_T + 1);
    localparam int GW    = $clog2(GAP_CYC + 1);

    seq_state_e          state;
    wait_cls_e           cls;
    logic [TW-1:0]       cnt;
    logic [TW-1:0]       limit;
    logic [GW-1:0]       gap_cnt;
    logic                gap_met;
    logic                pend_rb;
    logic                rsp_frame;
    logic                rdy_s;
    logic                take_cmd;
    logic                take_rsp;
    logic                shf_start;
    logic [FRAME_BITS-1:0] shf_word;
    logic [HW-1:0]       shf_half;
    logic                shf_done;
    logic [DATA_W-1:0]   shf_rx;
    logic                mon_ok;
    logic                mon_tout;
    cmd_t                fr;

    assign cmd_ready = (state == ST_IDLE);
    assign dev_rst_n = (state != ST_RST);
    assign gap_met   = (gap_cnt >= GW'(GAP_CYC));
    assign take_cmd  = cmd_ready && cmd_valid;
    assign take_rsp  = (state == ST_GAP) && gap_met && pend_rb;
    assign shf_start = take_cmd || take_rsp;
    assign shf_half  = take_rsp ? HW'(RB_HALF_CYC) : HW'(HALF_CYC);

    always_comb begin
        fr.code = take_rsp ? OP_NOP : cmd_code;
        fr.data = take_rsp ? '0 : cmd_data;
    end
    assign shf_word = pack_frame(fr);

    always_comb begin
        case (cls)
            CLS_READ: limit = TW'(TO_READ);
            CLS_LONG: limit = TW'(TO_LONG);
            default:  limit = TW'(TO_SHORT);
        endcase
    end

    scs_sync2 #(.STAGES(2), .RST_VAL(1'b1)) rdy_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (dev_rdy),
        .q   (rdy_s)
    );

    scs_frame_shift #(.NBITS(FRAME_BITS), .RX_W(DATA_W), .HW(HW)) shift_i (
        .clk   (clk),
        .rst   (rst),
        .start (shf_start),
        .word  (shf_word),
        .half  (shf_half),
        .din   (dev_din),
        .sel_n (dev_sel_n),
        .sclk  (dev_sclk),
        .dout  (dev_dout),
        .done  (shf_done),
        .rx    (shf_rx)
    );

    scs_busy_mon #(.TW(TW)) busy_i (
        .clk    (clk),
        .rst    (rst),
        .arm    (shf_done),
        .rdy_ok (rdy_s),
        .limit  (limit),
        .ok     (mon_ok),
        .tout   (mon_tout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_RST;
            cls         <= CLS_SHORT;
            cnt         <= '0;
            gap_cnt     <= '0;
            pend_rb     <= 1'b0;
            rsp_frame   <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
            err_timeout <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (!dev_sel_n)   gap_cnt <= '0;
            else if (!gap_met) gap_cnt <= gap_cnt + GW'(1);

            case (state)
                ST_RST: begin
                    if (cnt == TW'(RST_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_PWR;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end
                ST_PWR: begin
                    if (cnt == TW'(PWRUP_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cls       <= cls_of(cmd_code);
                        pend_rb   <= is_readback(cmd_code);
                        rsp_frame <= 1'b0;
                        state     <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (shf_done) state <= ST_BUSY;
                end
                ST_BUSY: begin
                    if (mon_ok) begin
                        if (rsp_frame) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= shf_rx;
                        end
                        state <= ST_GAP;
                    end else if (mon_tout) begin
                        err_timeout <= 1'b1;
                        pend_rb     <= 1'b0;
                        state       <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_met) begin
                        if (pend_rb) begin
                            pend_rb   <= 1'b0;
                            rsp_frame <= 1'b1;
                            cls       <= CLS_SHORT;
                            state     <= ST_FRAME;
                        end else begin
                            rsp_frame <= 1'b0;
                            state     <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_RST;
            endcase
        end
    end
endmodule

// File: rtl/ser_cmd_seq_chk.sv
module ser_cmd_seq_chk #(
    parameter int GAP_CYC = 8
) (
    input logic clk,
    input logic rst,
    input logic cmd_ready,
    input logic rsp_valid,
    input logic err_timeout,
    input logic dev_rst_n,
    input logic dev_sel_n,
    input logic dev_sclk,
    input logic dev_dout,
    input logic dev_rdy
);
    int hi_run;
    int rdy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run  <= 0;
            rdy_run <= 0;
        end else begin
            hi_run  <= dev_sel_n ? ((hi_run < GAP_CYC) ? hi_run + 1 : hi_run) : 0;
            rdy_run <= dev_rdy ? ((rdy_run < 4) ? rdy_run + 1 : rdy_run) : 0;
        end
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dev_rst_n |-> (dev_sel_n && !cmd_ready));

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        dev_sel_n |-> dev_sclk);

    // R2
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!dev_sel_n && !dev_sclk && $past(!dev_sclk)) |-> $stable(dev_dout));

    // R4
    gap_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_sel_n) |-> (hi_run >= GAP_CYC));

    // R5
    rdy_before_frame_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(dev_sel_n) && !err_timeout) |-> (rdy_run >= 2));

    // R7
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (dev_sel_n && dev_rst_n));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_timeout |=> err_timeout);
endmodule

bind ser_cmd_seq ser_cmd_seq_chk #(.GAP_CYC(GAP_CYC)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .err_timeout (err_timeout),
    .dev_rst_n   (dev_rst_n),
    .dev_sel_n   (dev_sel_n),
    .dev_sclk    (dev_sclk),
    .dev_dout    (dev_dout),
    .dev_rdy     (dev_rdy)
);

// File: tb/ser_cmd_seq_tb_top.sv
module ser_cmd_seq_tb_top;
    localparam int HALF = 2;
    localparam int RBH  = 4;
    localparam int GAP  = 8;
    localparam int RSTC = 4;
    localparam int PWR  = 20;
    localparam int TS   = 20;
    localparam int TR   = 60;
    localparam int TL   = 200;

    // fields: code[31:28] data[27:18] busy[17:10] resp[9:0]
    localparam logic [31:0] VEC [0:5] = '{
        {4'h1, 10'h3FF, 8'd4,   10'h000},
        {4'h2, 10'h000, 8'd6,   10'h2A5},
        {4'h0, 10'h155, 8'd3,   10'h000},
        {4'h5, 10'h001, 8'd10,  10'h15A},
        {4'h3, 10'h2AA, 8'd100, 10'h000},
        {4'h7, 10'h200, 8'd5,   10'h000}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [3:0] cmd_code = '0;
    logic [9:0] cmd_data = '0;
    logic       rsp_valid;
    logic [9:0] rsp_data;
    logic       err_timeout;
    logic       dev_rst_n, dev_sel_n, dev_sclk, dev_dout, dev_din;
    logic       dev_rdy = 1'b1;
    logic [15:0] out_sh = '0;

    assign dev_din = out_sh[15];

    ser_cmd_seq #(
        .HALF_CYC(HALF), .RB_HALF_CYC(RBH), .GAP_CYC(GAP), .RST_CYC(RSTC),
        .PWRUP_CYC(PWR), .TO_SHORT(TS), .TO_READ(TR), .TO_LONG(TL)
    ) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .err_timeout(err_timeout), .dev_rst_n(dev_rst_n),
        .dev_sel_n(dev_sel_n), .dev_sclk(dev_sclk), .dev_dout(dev_dout),
        .dev_din(dev_din), .dev_rdy(dev_rdy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // peripheral model, sampled away from the active edge
    int fw [0:63];
    int fl [0:63];
    int gp [0:63];
    int rh [0:63];
    int nfr = 0;
    int fstart = 0, last_rise = 0;
    int dly = 0, lowc = 0, rdy_hi = 100;
    int cur_busy = 4, busy_next = 4;
    logic [9:0] cur_resp = '0;
    logic [15:0] in_sh = '0;
    logic sel_q = 1'b1, sclk_q = 1'b1;
    int nrsp = 0;
    logic [9:0] rsp_last = '0;
    int ready_bad = 0;

    always @(negedge clk) begin
        if (dly > 0) begin
            dly--;
            if (dly == 0 && lowc > 0) dev_rdy = 1'b0;
        end else if (!dev_rdy && lowc > 0) begin
            lowc--;
            if (lowc == 0) dev_rdy = 1'b1;
        end
        rdy_hi = dev_rdy ? rdy_hi + 1 : 0;

        if (sel_q && !dev_sel_n) begin
            fstart = cyc;
            out_sh = {6'b101101, cur_resp};
            in_sh  = '0;
            if (nfr < 64) begin
                gp[nfr] = cyc - last_rise;
                rh[nfr] = rdy_hi;
            end
        end else if (!dev_sel_n && sclk_q && !dev_sclk) begin
            in_sh = {in_sh[14:0], dev_dout};
        end else if (!dev_sel_n && !sclk_q && dev_sclk) begin
            out_sh = {out_sh[14:0], 1'b0};
        end
        if (!sel_q && dev_sel_n) begin
            if (nfr < 64) begin
                fw[nfr] = int'(in_sh);
                fl[nfr] = cyc - fstart;
            end
            nfr++;
            last_rise = cyc;
            dly  = 2;
            lowc = cur_busy;
            cur_busy = busy_next;
        end
        sel_q  = dev_sel_n;
        sclk_q = dev_sclk;

        if (rsp_valid) begin
            nrsp++;
            rsp_last = rsp_data;
        end
        if (!dev_sel_n && cmd_ready) ready_bad++;
    end

    task automatic do_reset();
        int n;
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(dev_sel_n && dev_sclk && !cmd_ready && !dev_rst_n && !rsp_valid && !err_timeout,
            "R1 reset state", {dev_sel_n, dev_sclk, cmd_ready, dev_rst_n, rsp_valid, err_timeout}, 6'b110000);
        rst = 1'b0;
        n = 0;
        while (!dev_rst_n && n < 1000) begin n++; @(negedge clk); end
        chk(n == RSTC, "R1 peripheral reset width", n, RSTC);
        n = 0;
        while (!cmd_ready && n < 1000) begin n++; @(negedge clk); end
        chk(n == PWR, "R1 power-up wait", n, PWR);
    endtask

    task automatic send(input logic [3:0] c, input logic [9:0] d, input int busy, input logic [9:0] resp);
        int n;
        n = 0;
        while (!cmd_ready && n < 100000) begin n++; @(negedge clk); end
        cur_busy  = busy;
        busy_next = 4;
        cur_resp  = resp;
        cmd_code  = c;
        cmd_data  = d;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!cmd_ready && n < 100000) begin n++; @(negedge clk); end
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog (R5 handshake hang): actual %0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0, r0;
        logic [3:0] c;
        logic [9:0] d, rs;
        int b;
        bit rb;

        do_reset();

        for (int i = 0; i < 6; i++) begin
            c  = VEC[i][31:28];
            d  = VEC[i][27:18];
            b  = int'(VEC[i][17:10]);
            rs = VEC[i][9:0];
            rb = (c == 4'h2) || (c == 4'h5);
            n0 = nfr;
            r0 = nrsp;
            send(c, d, b, rs);
            chk(nfr == n0 + 1 + int'(rb), "R8 frame count", nfr - n0, 1 + int'(rb));
            chk(fw[n0] == int'({2'b00, c, d}), "R2 frame word", fw[n0], int'({2'b00, c, d}));
            chk(fl[n0] == 32 * HALF, "R3 frame length", fl[n0], 32 * HALF);
            chk(gp[n0] >= GAP, "R4 select gap", gp[n0], GAP);
            chk(rh[n0] >= 2, "R5 ready before frame", rh[n0], 2);
            if (rb) begin
                chk(fw[n0 + 1] == 0, "R8 response frame word", fw[n0 + 1], 0);
                chk(fl[n0 + 1] == 32 * RBH, "R8 response frame length", fl[n0 + 1], 32 * RBH);
                chk(gp[n0 + 1] >= GAP, "R4 gap before response frame", gp[n0 + 1], GAP);
                chk(nrsp == r0 + 1, "R8 one response pulse", nrsp - r0, 1);
                chk(rsp_last == rs, "R8 response data", int'(rsp_last), int'(rs));
            end else begin
                chk(nrsp == r0, "R8 no response for write", nrsp - r0, 0);
            end
            chk(err_timeout == 1'b0, "R9 wait within class limit", int'(err_timeout), 0);
        end

        // R9: register readback tolerates a wait the short class would not
        n0 = nfr; r0 = nrsp;
        send(4'h2, 10'h0AB, 40, 10'h1C3);
        chk(err_timeout == 1'b0, "R9 read class limit", int'(err_timeout), 0);
        chk(nrsp == r0 + 1 && rsp_last == 10'h1C3, "R9 read result after long wait", int'(rsp_last), 10'h1C3);

        // R6/R9: same wait on a short-class code times out
        n0 = nfr;
        send(4'h1, 10'h011, 40, 10'h000);
        chk(err_timeout == 1'b1, "R6 timeout flag", int'(err_timeout), 1);
        chk(nfr == n0 + 1, "R6 single frame on timeout", nfr - n0, 1);
        chk(cmd_ready == 1'b1, "R6 back to idle", int'(cmd_ready), 1);
        repeat (60) @(negedge clk);

        // R6: timed-out readback drops its response frame and result
        n0 = nfr; r0 = nrsp;
        send(4'h2, 10'h022, 100, 10'h3FF);
        chk(nfr == n0 + 1, "R6 response frame dropped", nfr - n0, 1);
        chk(nrsp == r0, "R6 no result after timeout", nrsp - r0, 0);
        chk(err_timeout == 1'b1, "R10 flag stays set", int'(err_timeout), 1);
        repeat (120) @(negedge clk);

        chk(ready_bad == 0, "R7 ready low during frames", ready_bad, 0);

        // R10: only reset clears the flag
        do_reset();
        chk(err_timeout == 1'b0, "R10 cleared by reset", int'(err_timeout), 0);
        n0 = nfr;
        send(4'h1, 10'h155, 4, 10'h000);
        chk(fw[n0] == int'({2'b00, 4'h1, 10'h155}), "R2 frame after reset", fw[n0], int'({2'b00, 4'h1, 10'h155}));
        chk(err_timeout == 1'b0, "R10 clean after reset", int'(err_timeout), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule